// File: doc/BRIEF.md
# Edge-Triggered GPIO Interrupt Merger

This block watches sixteen input pins, grouped as two 8-bit ports, and folds them into one GPIO interrupt request for the interrupt controller. Each pin has a polarity bit and an enable bit. The polarity bit picks whether the pin is active high or active low. The enable bit masks the pin. A pin that is enabled and sitting at its selected level raises its own condition. All sixteen conditions are ORed together. A request flag is set only on the cycle where that OR goes from low to high. A global enable gates the flag before it reaches the output. The interrupt controller clears the flag with an acknowledge pulse.

Pins are synchronised to the clock before anything else sees them. Software programs the block through a simple write port addressed by byte. Polarity registers live at addresses 0x00 (pins 7..0) and 0x01 (pins 15..8). Enable registers live at 0x04 (pins 7..0) and 0x05 (pins 15..8). The enable registers are write-only, so reading them returns zero.

Because every pin feeds a single OR, an edge on one pin is lost while another enabled pin is still held at its active level. Software is expected to know this.

Top module: `pinIrqMerge`

## Requirements
- R1: With polarity bit 1 a pin triggers on a low-to-high change, and with polarity bit 0 it triggers on a high-to-low change. The trigger condition for a pin is "synchronised level equals its polarity bit".
- R2: A pin whose enable bit is 0 never causes a request, whatever it does.
- R3: A write with `wrEn` high updates one register on the clock edge. Address 0x00 sets polarity for pins 7..0, 0x01 for pins 15..8, 0x04 sets enables for pins 7..0, and 0x05 for pins 15..8. Data bit k maps to pin k of that port.
- R4: After reset all polarity and enable bits are 0 and `irqReq` is low.
- R5: Reading address 0x04 or 0x05 returns 0. Reading 0x00 or 0x01 returns the polarity byte of that port. Any other address reads 0. The read path is combinational from `rdAddr`.
- R6: The request flag is set only when the OR of all enabled pin conditions rises. An edge on a pin while another enabled pin already holds its active level sets nothing, and a held level sets the flag only once.
- R7: A change on `pinIn` that creates an OR rise shows on `irqReq` after the third rising clock edge: two synchroniser stages, then the flag.
- R8: `irqReq` equals the flag ANDed with `globalEn`. While `globalEn` is low the flag can still be set, and it appears as soon as `globalEn` returns high.
- R9: `irqAck` high at a clock edge clears the flag. If an OR rise happens at the same edge, setting wins.
- R10: Enabling a pin, or changing its polarity, so that it becomes active counts as an OR rise. A request follows one edge after the register write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 16 | Asynchronous pin levels, port 1 in bits 15..8 |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 8 | Register read address |
| rdData | output | 8 | Register read data |
| globalEn | input | 1 | Global GPIO interrupt enable |
| irqAck | input | 1 | Clears the request flag |
| irqReq | output | 1 | Gated GPIO interrupt request |

## Verification
The hardest case to reach from the ports is a lost edge. One enabled pin must hold its active level through the synchroniser while a second enabled pin makes a valid transition. The flag must stay low, and it must set again only after both pins have gone idle and a fresh edge arrives. Directed steps build this situation on purpose, including the case where an acknowledge coincides with a new rise. A long random phase then toggles single pins, rewrites polarity and enable bytes, and drops the global enable and acknowledge. Each cycle is compared against a bench-side model of the requirements.

// File: rtl/pinIrqPkg.sv
package pinIrqPkg;
  localparam int PORT_CNT = 2;

  typedef struct packed {
    logic [PORT_CNT-1:0] polWr;
    logic [PORT_CNT-1:0] enWr;
    logic [PORT_CNT-1:0] polRd;
  } regStrobe_t;
endpackage

// File: rtl/pinIrqSync.sv
module pinIrqSync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/pinIrqCtrl.sv
module pinIrqCtrl import pinIrqPkg::*; #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] POL_BASE = 'h00,
  parameter logic [ADDR_W-1:0] EN_BASE  = 'h04
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  output regStrobe_t        stb
);
  for (genvar p = 0; p < PORT_CNT; p++) begin : g_dec
    assign stb.polWr[p] = wrEn && (wrAddr == POL_BASE + ADDR_W'(p));
    assign stb.enWr[p]  = wrEn && (wrAddr == EN_BASE + ADDR_W'(p));
    assign stb.polRd[p] = (rdAddr == POL_BASE + ADDR_W'(p));
  end

  // R3
  wrOnehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.polWr, stb.enWr}));

  // R5
  rdOnehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.polRd));
endmodule

// File: rtl/pinIrqDatapath.sv
module pinIrqDatapath import pinIrqPkg::*; #(
  parameter int PORT_W = 8,
  parameter int PIN_N  = PORT_CNT * PORT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PIN_N-1:0]  pinIn,
  input  logic [PORT_W-1:0] wrData,
  input  regStrobe_t        stb,
  input  logic              globalEn,
  input  logic              irqAck,
  output logic [PORT_W-1:0] rdData,
  output logic              irqReq
);
  logic [PIN_N-1:0] pinSync;
  logic [PIN_N-1:0] polBits;
  logic [PIN_N-1:0] enBits;
  logic [PIN_N-1:0] qualified;
  logic             anyCond;
  logic             anyPrev;
  logic             orRise;
  logic             reqFf;

  pinIrqSync #(.W(PIN_N), .STAGES(2)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (pinIn),
    .syncOut (pinSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polBits <= '0;
      enBits  <= '0;
    end else begin
      for (int p = 0; p < PORT_CNT; p++) begin
        if (stb.polWr[p]) polBits[p*PORT_W +: PORT_W] <= wrData;
        if (stb.enWr[p])  enBits[p*PORT_W +: PORT_W]  <= wrData;
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int p = 0; p < PORT_CNT; p++)
      if (stb.polRd[p]) rdData = polBits[p*PORT_W +: PORT_W];
  end

  assign qualified = ~(pinSync ^ polBits) & enBits;
  assign anyCond   = |qualified;
  assign orRise    = anyCond && !anyPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      anyPrev <= 1'b0;
      reqFf   <= 1'b0;
    end else begin
      anyPrev <= anyCond;
      if (orRise)      reqFf <= 1'b1;
      else if (irqAck) reqFf <= 1'b0;
    end
  end

  assign irqReq = reqFf && globalEn;

  // R6
  setSource_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqFf) |-> $past(anyCond && !anyPrev));

  // R9
  ackClear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !orRise) |=> !reqFf);

  // R2
  enHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.enWr == '0) |=> $stable(enBits));

  // R4
  resetIdle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!reqFf && enBits == '0));
endmodule

// File: rtl/pinIrqMerge.sv
module pinIrqMerge import pinIrqPkg::*; #(
  parameter int                PORT_W   = 8,
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] POL_BASE = 'h00,
  parameter logic [ADDR_W-1:0] EN_BASE  = 'h04
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [PORT_CNT*PORT_W-1:0]  pinIn,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [PORT_W-1:0]           wrData,
  input  logic [ADDR_W-1:0]           rdAddr,
  output logic [PORT_W-1:0]           rdData,
  input  logic                        globalEn,
  input  logic                        irqAck,
  output logic                        irqReq
);
  localparam int PIN_N = PORT_CNT * PORT_W;

  regStrobe_t stb;

  pinIrqCtrl #(
    .ADDR_W   (ADDR_W),
    .POL_BASE (POL_BASE),
    .EN_BASE  (EN_BASE)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .stb    (stb)
  );

  pinIrqDatapath #(.PORT_W(PORT_W), .PIN_N(PIN_N)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (pinIn),
    .wrData   (wrData),
    .stb      (stb),
    .globalEn (globalEn),
    .irqAck   (irqAck),
    .rdData   (rdData),
    .irqReq   (irqReq)
  );

  // R8
  gateOff_chk: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |-> !irqReq);

  for (genvar p = 0; p < PORT_CNT; p++) begin : g_rdChk
    // R5
    enReadZero_chk: assert property (@(posedge clk) disable iff (!rstN)
      (rdAddr == EN_BASE + ADDR_W'(p)) |-> (rdData == '0));
  end
endmodule

// File: tb/tb_pinIrqMerge.sv
module tb_pinIrqMerge;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] pinIn;
  logic        wrEn;
  logic [7:0]  wrAddr, wrData, rdAddr, rdData;
  logic        globalEn, irqAck, irqReq;
  int          nChk = 0;
  int          nBad = 0;

  always #(CLK_P/2) clk = ~clk;

  pinIrqMerge dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .globalEn(globalEn),
    .irqAck(irqAck), .irqReq(irqReq)
  );

  // Requirement-level model
  logic [15:0] mS1, mS2, mPol, mEn;
  logic        mPrev, mReq, mAny;

  function automatic logic orCond(input logic [15:0] lvl, input logic [15:0] pol,
                                  input logic [15:0] en);
    return |(~(lvl ^ pol) & en);
  endfunction

  function automatic logic [7:0] expRd(input logic [7:0] a);
    if (a == 8'h00) return mPol[7:0];
    if (a == 8'h01) return mPol[15:8];
    return 8'h00;
  endfunction

  assign mAny = orCond(mS2, mPol, mEn);

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 <= '0; mS2 <= '0; mPol <= '0; mEn <= '0; mPrev <= 1'b0; mReq <= 1'b0;
    end else begin
      mS1   <= pinIn;
      mS2   <= mS1;
      mPrev <= mAny;
      if (mAny && !mPrev) mReq <= 1'b1;
      else if (irqAck)    mReq <= 1'b0;
      if (wrEn) begin
        case (wrAddr)
          8'h00: mPol[7:0]  <= wrData;
          8'h01: mPol[15:8] <= wrData;
          8'h04: mEn[7:0]   <= wrData;
          8'h05: mEn[15:8]  <= wrData;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    tick(1);
    wrEn = 1'b0;
  endtask

  task automatic ackPulse();
    irqAck = 1'b1;
    tick(1);
    irqAck = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    rdAddr = a;
    #1;
    chk(tag, {8'h00, rdData}, {8'h00, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rstN = 1'b0; pinIn = '0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    rdAddr = '0; globalEn = 1'b1; irqAck = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick(1);

    // R4 reset state
    chk("R4 irqReq after reset", {15'd0, irqReq}, 16'd0);
    rdChk("R4 polarity port0 after reset", 8'h00, 8'h00);
    rdChk("R4 polarity port1 after reset", 8'h01, 8'h00);

    // R1 rising trigger with R7 latency
    wr(8'h00, 8'hFF); wr(8'h01, 8'hFF); wr(8'h04, 8'h01);
    tick(3);
    chk("R1 inactive pin no request", {15'd0, irqReq}, 16'd0);
    pinIn[0] = 1'b1;
    tick(2);
    chk("R7 not yet after two edges", {15'd0, irqReq}, 16'd0);
    tick(1);
    chk("R1 R7 rising edge request", {15'd0, irqReq}, 16'd1);

    // R9 acknowledge, R6 held level does not retrigger
    ackPulse();
    chk("R9 ack clears", {15'd0, irqReq}, 16'd0);
    tick(3);
    chk("R6 held level no retrigger", {15'd0, irqReq}, 16'd0);

    // R8 global gate
    pinIn[0] = 1'b0; tick(3);
    globalEn = 1'b0; pinIn[0] = 1'b1; tick(3);
    chk("R8 gated off", {15'd0, irqReq}, 16'd0);
    globalEn = 1'b1; #1;
    chk("R8 flag kept while gated", {15'd0, irqReq}, 16'd1);
    ackPulse();
    chk("R9 ack clears after gate", {15'd0, irqReq}, 16'd0);

    // R6 missed edge while another pin holds the OR high
    wr(8'h04, 8'h03);
    pinIn[1] = 1'b1; tick(3);
    chk("R6 edge masked by held pin", {15'd0, irqReq}, 16'd0);
    pinIn[0] = 1'b0; pinIn[1] = 1'b0; tick(3);
    pinIn[1] = 1'b1; tick(3);
    chk("R6 edge after idle sets", {15'd0, irqReq}, 16'd1);
    ackPulse();

    // R1 falling trigger on pin 1
    wr(8'h00, 8'hFD);
    pinIn[1] = 1'b0; tick(3);
    chk("R1 falling edge request", {15'd0, irqReq}, 16'd1);
    ackPulse();
    chk("R9 ack after falling", {15'd0, irqReq}, 16'd0);

    // R2 disabled pin ignored
    pinIn[1] = 1'b1; tick(3);
    pinIn[2] = 1'b1; tick(3);
    chk("R2 disabled pin rise", {15'd0, irqReq}, 16'd0);
    pinIn[2] = 1'b0; tick(3);
    chk("R2 disabled pin fall", {15'd0, irqReq}, 16'd0);

    // R3 port 1 enable at 0x05
    wr(8'h05, 8'h80);
    pinIn[15] = 1'b1; tick(3);
    chk("R3 port1 pin15 request", {15'd0, irqReq}, 16'd1);
    ackPulse();

    // R10 enabling an already active pin
    wr(8'h05, 8'h00); wr(8'h01, 8'h00);
    ackPulse();
    chk("R10 idle before enable", {15'd0, irqReq}, 16'd0);
    wr(8'h05, 8'h40);
    tick(1);
    chk("R10 enable of active pin requests", {15'd0, irqReq}, 16'd1);
    ackPulse();
    chk("R9 ack after enable request", {15'd0, irqReq}, 16'd0);

    // R5 reads
    rdChk("R5 read 0x04 zero", 8'h04, 8'h00);
    rdChk("R5 read 0x05 zero", 8'h05, 8'h00);
    rdChk("R5 read polarity port0", 8'h00, 8'hFD);
    rdChk("R5 read polarity port1", 8'h01, 8'h00);
    rdChk("R5 read unused address", 8'h07, 8'h00);

    // R9 set wins over a coincident ack
    pinIn[14] = 1'b1; tick(3);
    irqAck = 1'b1; pinIn[14] = 1'b0; tick(3);
    chk("R9 set wins over ack", {15'd0, irqReq}, 16'd1);
    tick(1);
    chk("R9 held ack clears", {15'd0, irqReq}, 16'd0);
    irqAck = 1'b0;

    // Random phase against the model
    for (int i = 0; i < 1500; i++) begin
      tick(1);
      chk("R1/R2/R6/R8/R9 random irqReq", {15'd0, irqReq}, {15'd0, mReq & globalEn});
      chk("R3/R5 random rdData", {8'h00, rdData}, {8'h00, expRd(rdAddr)});
      if ($urandom % 3 == 0) pinIn = pinIn ^ (16'h1 << ($urandom % 16));
      wrEn = ($urandom % 10 == 0);
      case ($urandom % 5)
        0: wrAddr = 8'h00;
        1: wrAddr = 8'h01;
        2: wrAddr = 8'h04;
        3: wrAddr = 8'h05;
        default: wrAddr = 8'($urandom % 16);
      endcase
      wrData   = 8'($urandom);
      rdAddr   = 8'($urandom % 8);
      globalEn = ($urandom % 8 != 0);
      irqAck   = ($urandom % 8 == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule